// File: doc/BRIEF.md
# Row Tag Allocator for a Pipelined Reduction Unit

This block labels an incoming stream of values that are grouped into rows. Each value arrives with a row-start flag and a row-end flag. The block gives the first value of every row a small tag taken from a bounded pool. Every later value of that row carries the same tag. The surrounding reduction datapath uses the tag to decide which values may be combined with each other, and which slot of its result buffer holds a row's partial result.

A tag stays reserved until its row cannot change any more. The block sets that moment at a fixed delay after the row's final value. The delay depends only on the depth `DEPTH` of the operator pipeline: DRAIN = 2·DEPTH + DEPTH·ceil(log2 DEPTH) + 1 cycles. When the delay runs out, the block raises a one-cycle ready strobe carrying the tag, and the datapath reads the finished result from that slot. Tags are handed out strictly in turn and every row waits the same delay, so ready strobes come out in the order the rows arrived.

The pool size depends only on `DEPTH` and on an optional guaranteed minimum row length `MIN_ROW_LEN`: POOL = ceil((DRAIN−1)/MIN_ROW_LEN) + 1. With single-value rows this equals DRAIN. Longer guaranteed rows shrink the pool, down to two tags.

Top module: `rta_row_tag_alloc`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_valid` is 0. The first row after reset receives tag 0.
- R2: A value with `in_valid`=1 and `in_first`=1 receives the next tag in the sequence 0, 1, …, POOL−1, 0, … on `val_tag` in the same cycle. Tags are always below POOL.
- R3: A value with `in_valid`=1 and `in_first`=0 carries on `val_tag` the tag of the row most recently opened.
- R4: Suppose the last value of a row (`in_valid`=1, `in_last`=1) is presented in cycle c. Then `done_valid`=1 with `done_tag` equal to that row's tag in cycle c+DRAIN, and in no other cycle for that row.
- R5: A row of one value (`in_first`=1 and `in_last`=1 together) is both tagged and scheduled for completion in that one cycle.
- R6: Cycles with `in_valid`=0 are ignored, whatever `in_first` and `in_last` hold. They neither advance the tag sequence nor schedule a strobe.
- R7: With the default DEPTH=4 and MIN_ROW_LEN=1, DRAIN=17 and the pool holds 17 tags, so the tag after 16 is 0. With DEPTH=10 and MIN_ROW_LEN=60, DRAIN=61 and the pool holds 2 tags.
- R8: A tag whose ready strobe is active in a cycle may be issued to a new row in that same cycle. A tag is never issued while its previous row is still open or draining.
- R9: At most one ready strobe occurs per cycle. Strobes follow row arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A value is present this cycle |
| in_first | input | 1 | This value opens a new row |
| in_last | input | 1 | This value closes its row |
| val_tag | output | TAG_W | Tag for the present value (same cycle) |
| done_valid | output | 1 | A row's result is final this cycle |
| done_tag | output | TAG_W | Tag of the row whose result is final |

## Verification
Most internal faults in this block reach the ports within one row. A cursor that steps wrongly shows up on `val_tag` at the very next row start. A slot that drops its hold shows up as a wrong tag on the next value of the same row. A drain counter that is loaded or decremented wrongly moves `done_valid` off the exact cycle c+DRAIN. That is seen DRAIN cycles after the row closes, as a missing, early or late strobe. A slot that is freed too early or too late only becomes visible once the cycle of tags wraps back to it. The bench therefore runs back-to-back single-value rows past one full wrap, where a freed slot is reissued in its own strobe cycle.

// File: rtl/rta_pkg.sv
package rta_pkg;

   // cycles between a row's final value and the moment its result is settled
   function automatic int drain_cycles(input int depth);
      return 2 * depth + depth * $clog2(depth) + 1;
   endfunction

   // ceil((drain-1)/min_len) + 1 tags are enough when rows are at least min_len long
   function automatic int pool_size(input int depth, input int min_len);
      return (drain_cycles(depth) - 2 + min_len) / min_len + 1;
   endfunction

   typedef enum logic [1:0] {
      SLOT_IDLE  = 2'd0,
      SLOT_OPEN  = 2'd1,
      SLOT_DRAIN = 2'd2
   } slot_state_t;

endpackage

// File: rtl/rta_tag_cursor.sv
module rta_tag_cursor #(
   parameter int POOL  = 17,
   parameter int TAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_hit,
   output logic [TAG_W-1:0] val_tag
);
   localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(POOL - 1);
   localparam bit POW2 = ((1 << TAG_W) == POOL);

   logic [TAG_W-1:0] issue_ptr;
   logic [TAG_W-1:0] row_tag;
   logic [TAG_W-1:0] step_ptr;

   generate
      if (POW2) begin : g_wrap_free
         // natural overflow wraps the pointer
         assign step_ptr = issue_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign step_ptr = (issue_ptr == LAST_TAG) ? '0 : issue_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_ptr <= '0;
         row_tag   <= '0;
      end else if (open_hit) begin
         issue_ptr <= step_ptr;
         row_tag   <= issue_ptr;
      end
   end

   assign val_tag = open_hit ? issue_ptr : row_tag;

endmodule

// File: rtl/rta_drain_timer.sv
module rta_drain_timer
   import rta_pkg::*;
#(
   parameter int POOL  = 17,
   parameter int DRAIN = 17,
   parameter int TAG_W = 5,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_hit,
   input  logic             close_hit,
   input  logic [TAG_W-1:0] val_tag,
   output logic [POOL-1:0]  busy_vec,
   output logic [POOL-1:0]  strobe_vec
);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(DRAIN - 1);

   generate
      for (genvar t = 0; t < POOL; t++) begin : g_slot
         slot_state_t      st;
         logic [CNT_W-1:0] cnt;
         logic             sel;

         assign sel = (val_tag == TAG_W'(t));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st  <= SLOT_IDLE;
               cnt <= '0;
            end else if (close_hit && sel) begin
               st  <= SLOT_DRAIN;
               cnt <= LOAD;
            end else if (open_hit && sel) begin
               st <= SLOT_OPEN;
            end else if (st == SLOT_DRAIN) begin
               if (cnt == '0) st <= SLOT_IDLE;
               else           cnt <= cnt - 1'b1;
            end
         end

         assign busy_vec[t]   = (st != SLOT_IDLE);
         assign strobe_vec[t] = (st == SLOT_DRAIN) && (cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/rta_done_encode.sv
module rta_done_encode #(
   parameter int POOL  = 17,
   parameter int TAG_W = 5
) (
   input  logic [POOL-1:0]  strobe_vec,
   output logic             done_valid,
   output logic [TAG_W-1:0] done_tag
);
   always_comb begin
      done_tag = '0;
      for (int i = 0; i < POOL; i++) begin
         if (strobe_vec[i]) done_tag = done_tag | TAG_W'(i);
      end
   end

   assign done_valid = |strobe_vec;

endmodule

// File: rtl/rta_row_tag_alloc.sv
module rta_row_tag_alloc
   import rta_pkg::*;
#(
   parameter int DEPTH       = 4,
   parameter int MIN_ROW_LEN = 1,
   localparam int DRAIN      = drain_cycles(DEPTH),
   localparam int POOL       = pool_size(DEPTH, MIN_ROW_LEN),
   localparam int TAG_W      = (POOL > 1) ? $clog2(POOL) : 1,
   localparam int CNT_W      = $clog2(DRAIN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_first,
   input  logic             in_last,
   output logic [TAG_W-1:0] val_tag,
   output logic             done_valid,
   output logic [TAG_W-1:0] done_tag
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("rta_row_tag_alloc: DEPTH must be at least 1");
      end
      if (MIN_ROW_LEN < 1) begin : g_bad_min
         $error("rta_row_tag_alloc: MIN_ROW_LEN must be at least 1");
      end
   endgenerate

   logic            open_hit;
   logic            close_hit;
   logic [POOL-1:0] busy_vec;
   logic [POOL-1:0] strobe_vec;

   assign open_hit  = in_valid & in_first;
   assign close_hit = in_valid & in_last;

   rta_tag_cursor #(.POOL(POOL), .TAG_W(TAG_W)) cursor_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_hit (open_hit),
      .val_tag  (val_tag)
   );

   rta_drain_timer #(.POOL(POOL), .DRAIN(DRAIN), .TAG_W(TAG_W), .CNT_W(CNT_W)) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_hit   (open_hit),
      .close_hit  (close_hit),
      .val_tag    (val_tag),
      .busy_vec   (busy_vec),
      .strobe_vec (strobe_vec)
   );

   rta_done_encode #(.POOL(POOL), .TAG_W(TAG_W)) encode_i (
      .strobe_vec (strobe_vec),
      .done_valid (done_valid),
      .done_tag   (done_tag)
   );

endmodule

// File: rtl/rta_row_tag_alloc_chk.sv
module rta_row_tag_alloc_chk #(
   parameter int POOL  = 17,
   parameter int TAG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_first,
   input logic             in_last,
   input logic [TAG_W-1:0] val_tag,
   input logic             done_valid,
   input logic [TAG_W-1:0] done_tag,
   input logic [POOL-1:0]  busy_vec,
   input logic [POOL-1:0]  strobe_vec
);
   logic             seen_row;
   logic [TAG_W-1:0] held_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_row <= 1'b0;
         held_tag <= '0;
      end else if (in_valid && in_first) begin
         seen_row <= 1'b1;
         held_tag <= val_tag;
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !done_valid);

   // R2
   tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (int'(val_tag) < POOL));

   // R2
   rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_first && seen_row) |->
         (int'(val_tag) == ((int'(held_tag) == POOL - 1) ? 0 : int'(held_tag) + 1)));

   // R3
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_first && seen_row) |-> (val_tag == held_tag));

   // R8
   no_busy_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_first) |-> (!busy_vec[val_tag] || strobe_vec[val_tag]));

   // R9
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobe_vec));

   // R4
   strobe_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !(in_valid && in_first && val_tag == done_tag)) |=>
         !busy_vec[$past(done_tag)]);

endmodule

bind rta_row_tag_alloc rta_row_tag_alloc_chk #(.POOL(POOL), .TAG_W(TAG_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_first   (in_first),
   .in_last    (in_last),
   .val_tag    (val_tag),
   .done_valid (done_valid),
   .done_tag   (done_tag),
   .busy_vec   (busy_vec),
   .strobe_vec (strobe_vec)
);

// File: tb/rta_row_tag_alloc_tb_top.sv
module rta_row_tag_alloc_tb_top;
   localparam int A0 = 4;
   localparam int M0 = 1;
   localparam int A1 = 10;
   localparam int M1 = 60;

   function automatic int b_drain(input int a);
      return 2 * a + a * $clog2(a) + 1;
   endfunction
   function automatic int b_pool(input int a, input int m);
      return (b_drain(a) - 1 + m - 1) / m + 1;
   endfunction

   localparam int D0 = b_drain(A0);
   localparam int P0 = b_pool(A0, M0);
   localparam int D1 = b_drain(A1);
   localparam int P1 = b_pool(A1, M1);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n;
   logic       v0, f0, l0, v1, f1, l1;
   logic [4:0] t0, dt0;
   logic [0:0] t1, dt1;
   logic       dv0, dv1;

   rta_row_tag_alloc #(.DEPTH(A0), .MIN_ROW_LEN(M0)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_first(f0), .in_last(l0),
      .val_tag(t0), .done_valid(dv0), .done_tag(dt0));

   rta_row_tag_alloc #(.DEPTH(A1), .MIN_ROW_LEN(M1)) dut2_i (
      .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_first(f1), .in_last(l1),
      .val_tag(t1), .done_valid(dv1), .done_tag(dt1));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0;
   int bad = 0;
   int nt[2];
   int cur[2];
   int due0[$];
   int tg0[$];
   int due1[$];
   int tg1[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // driver: presents one value and pushes the expected strobe into the scoreboard
   task automatic drive(input int u, input bit f, input bit l, input string req);
      int exp;
      int act;
      @(negedge clk);
      if (u == 0) begin v0 = 1'b1; f0 = f; l0 = l; end
      else        begin v1 = 1'b1; f1 = f; l1 = l; end
      #2;
      if (f) begin
         exp    = nt[u];
         nt[u]  = (nt[u] + 1) % ((u == 0) ? P0 : P1);
         cur[u] = exp;
      end else begin
         exp = cur[u];
      end
      act = (u == 0) ? int'(t0) : int'(t1);
      chk(act == exp, req, act, exp);
      if (l) begin
         if (u == 0) begin due0.push_back(cyc + D0); tg0.push_back(exp); end
         else        begin due1.push_back(cyc + D1); tg1.push_back(exp); end
      end
   endtask

   task automatic idle(input int u, input int n, input bit junk);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (u == 0) begin v0 = 1'b0; f0 = junk; l0 = junk; end
         else        begin v1 = 1'b0; f1 = junk; l1 = junk; end
      end
   endtask

   // monitor: pops the scoreboard when a strobe is due, flags any other strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (due0.size() > 0 && due0[0] == cyc) begin
            chk(dv0 && int'(dt0) == tg0[0], "R4 strobe timing/tag (unit 0)",
                dv0 ? int'(dt0) : -1, tg0[0]);
            void'(due0.pop_front());
            void'(tg0.pop_front());
         end else if (dv0) begin
            chk(1'b0, "R9 unexpected strobe (unit 0)", int'(dt0), -1);
         end
         if (due1.size() > 0 && due1[0] == cyc) begin
            chk(dv1 && int'(dt1) == tg1[0], "R4 strobe timing/tag (unit 1)",
                dv1 ? int'(dt1) : -1, tg1[0]);
            void'(due1.pop_front());
            void'(tg1.pop_front());
         end else if (dv1) begin
            chk(1'b0, "R9 unexpected strobe (unit 1)", int'(dt1), -1);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      nt[0] = 0; nt[1] = 0; cur[0] = 0; cur[1] = 0;
      rst_n = 1'b0;
      v0 = 0; f0 = 0; l0 = 0; v1 = 0; f1 = 0; l1 = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!dv0 && !dv1, "R1 strobe low in reset", int'(dv0) + int'(dv1), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!dv0 && !dv1, "R1 strobe low after reset", int'(dv0) + int'(dv1), 0);

      // R1: first row gets tag 0; R5/R7/R8: 40 single-value rows wrap the 17-tag pool
      drive(0, 1'b1, 1'b1, "R1 first tag");
      for (int i = 1; i < 40; i++) drive(0, 1'b1, 1'b1, "R7 R5 R8 single-value row tag");

      // R6: flags with in_valid low must be ignored
      idle(0, 5, 1'b1);

      // R2/R3: rows of varied length with gaps
      for (int len = 1; len <= 6; len++) begin
         drive(0, 1'b1, len == 1, "R2 row start tag");
         for (int k = 1; k < len; k++) drive(0, 1'b0, k == len - 1, "R3 in-row tag");
         idle(0, len % 3, 1'b0);
      end
      idle(0, 1, 1'b0);

      // R7: second unit with a 2-tag pool and rows of at least 60 values
      for (int r = 0; r < 5; r++) begin
         int len;
         len = 60 + (r % 3);
         drive(1, 1'b1, 1'b0, "R7 R2 two-tag pool start");
         for (int k = 1; k < len; k++) drive(1, 1'b0, k == len - 1, "R3 long row tag");
      end
      idle(1, 1, 1'b0);

      repeat (D1 + 10) @(negedge clk);
      chk(due0.size() == 0, "R4 all unit 0 strobes seen", due0.size(), 0);
      chk(due1.size() == 0, "R4 all unit 1 strobes seen", due1.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule